// File: doc/BRIEF.md
# Hidden Configuration Register Window

This block sits between a host and the task-file ports of a legacy programmed-I/O disk interface. Normally every host read and write, byte or word, goes straight through to the task file, and read data comes back from it. The block also watches the host cycles for a fixed unlock pattern. When it sees the pattern, a hidden bank of configuration registers takes over the same small address range. The window stays open until a closing key is written.

Inside the window, byte accesses reach these registers:
- read-cycle timing and write-cycle timing, kept as two selectable sets, A and B;
- a control register that decides which set each drive uses;
- a read-only strap that reports the bus clock;
- a miscellaneous register whose low bit picks the set that timing writes go to.

The block drives registered timing values for drive 0 and drive 1, plus the miscellaneous byte that both drives share (address setup, ready timing, prefetch). Disk transfer sequencing is done elsewhere.

Top module: `hidden_cfg_window`

## Requirements
- R1: While the window is closed, the task-file address, size, write data and strobes follow the host's, and host_rdata equals tf_rdata.
- R2: The window opens after two consecutive word reads at offset 1 followed by a byte write of 0x03 at offset 2. Further word reads at offset 1 before that write keep the pattern armed.
- R3: Any other host cycle during the pattern restarts it. This includes a byte read at offset 1, a word write of 3, or a byte write of any other value at offset 2. The window then stays closed.
- R4: While the window is open, tf_rd and tf_wr stay low. Byte accesses at offset N reach hidden index N, and read data is the register byte zero-extended to 16 bits.
- R5: A byte write of 0x83 at offset 2 while the window is open closes it and restores pass-through.
- R6: Index 5 reads 0x01 if strap_pin was high during reset and 0x00 otherwise. Host writes to it, and later changes on the pin, have no effect.
- R7: Bit 0 of the miscellaneous register (index 6) chooses the target of timing writes: 0 selects set A, 1 selects set B. Index 0 holds read timing and index 1 holds write timing. Reads of index 0 and 1 return the selected set.
- R8: Writes to set B are dropped until 0xC0 has been written at offset 3 while the window was closed.
- R9: While the control register (index 3) holds 0x85, drive 1 timing outputs show set B. Otherwise both drives show set A. Drive 0 always shows set A. Outputs follow one cycle after the register changes.
- R10: shared_cfg shows the miscellaneous register value one cycle after it is written.
- R11: After reset, all timing values are 0xFF, control and miscellaneous are 0x00, and indices 2, 4 and 7 read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Host register offset |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_word | input | 1 | 1 = 16-bit cycle, 0 = byte cycle |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| tf_addr | output | 3 | Task-file register offset |
| tf_rd | output | 1 | Task-file read strobe |
| tf_wr | output | 1 | Task-file write strobe |
| tf_word | output | 1 | Task-file cycle size |
| tf_wdata | output | 16 | Task-file write data |
| tf_rdata | input | 16 | Task-file read data |
| strap_pin | input | 1 | Clock-speed strap, sampled during reset |
| drv0_rd_tim | output | 8 | Drive 0 read-cycle timing |
| drv0_wr_tim | output | 8 | Drive 0 write-cycle timing |
| drv1_rd_tim | output | 8 | Drive 1 read-cycle timing |
| drv1_wr_tim | output | 8 | Drive 1 write-cycle timing |
| shared_cfg | output | 8 | Miscellaneous settings shared by both drives |

## Verification
The bench tries to break the unlock pattern in several ways: a byte read among the word reads, a word write of the key, and a wrong key value. A detector that does not restart on a stray cycle would then expose the hidden bank through the task-file addresses. It arms the pattern with three word reads to confirm that extra reads do not disarm it. It also writes set B before and after the 0xC0 enable, so a bank without that gate would change its readback. It moves the control register on and off 0x85 and checks that drive 1 follows. Finally it drives the strap pin differently after reset and writes index 5, so a strap that is live or writable would read back the wrong clock.

// File: rtl/hcw_pkg.sv
package hcw_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ONE, SEQ_TWO} seq_t;

  localparam int IDX_RDTIM = 0;
  localparam int IDX_WRTIM = 1;
  localparam int IDX_CTRL  = 3;
  localparam int IDX_STRAP = 5;
  localparam int IDX_MISC  = 6;

  localparam int OFS_ARM   = 1;
  localparam int OFS_KEY   = 2;

  localparam logic [7:0] KEY_OPEN  = 8'h03;
  localparam logic [7:0] KEY_CLOSE = 8'h83;
  localparam logic [7:0] KEY_BEN   = 8'hC0;
  localparam logic [7:0] KEY_SPLIT = 8'h85;
endpackage

// File: rtl/hcw_unlock.sv
module hcw_unlock
  import hcw_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              word,
  input  logic [REG_W-1:0]  wbyte,
  output logic              win_open,
  output seq_t              seq_q
);
  logic arm_hit, key_hit, close_hit;

  assign arm_hit   = rd && word && (addr == ADDR_W'(OFS_ARM));
  assign key_hit   = wr && !word && (addr == ADDR_W'(OFS_KEY)) && (wbyte == KEY_OPEN);
  assign close_hit = wr && !word && (addr == ADDR_W'(OFS_KEY)) && (wbyte == KEY_CLOSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q    <= SEQ_IDLE;
      win_open <= 1'b0;
    end else if (win_open) begin
      seq_q <= SEQ_IDLE;
      if (close_hit) win_open <= 1'b0;
    end else if (rd || wr) begin
      if (arm_hit) begin
        seq_q <= (seq_q == SEQ_IDLE) ? SEQ_ONE : SEQ_TWO;
      end else if (key_hit && (seq_q == SEQ_TWO)) begin
        seq_q    <= SEQ_IDLE;
        win_open <= 1'b1;
      end else begin
        seq_q <= SEQ_IDLE;
      end
    end
  end
endmodule

// File: rtl/hcw_bank.sv
module hcw_bank
  import hcw_pkg::*;
#(
  parameter int          ADDR_W  = 3,
  parameter int          REG_W   = 8,
  parameter logic [7:0]  TIM_RST = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_pin,
  input  logic              win_open,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              word,
  input  logic [REG_W-1:0]  wbyte,
  output logic [REG_W-1:0]  rbyte,
  output logic [REG_W-1:0]  a_rd,
  output logic [REG_W-1:0]  a_wr,
  output logic [REG_W-1:0]  b_rd,
  output logic [REG_W-1:0]  b_wr,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [REG_W-1:0]  misc_q,
  output logic [REG_W-1:0]  strap_q,
  output logic              b_en_q
);
  localparam int NSETS = 2;

  logic hw, sel;
  assign hw  = win_open && wr && !word;
  assign sel = misc_q[0];

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    logic [REG_W-1:0] rd_q, wr_q;
    logic             wen;
    assign wen = hw && (sel == 1'(s)) && ((s == 0) || b_en_q);
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_q <= REG_W'(TIM_RST);
        wr_q <= REG_W'(TIM_RST);
      end else if (wen) begin
        if (addr == ADDR_W'(IDX_RDTIM)) rd_q <= wbyte;
        if (addr == ADDR_W'(IDX_WRTIM)) wr_q <= wbyte;
      end
    end
  end

  assign a_rd = g_set[0].rd_q;
  assign a_wr = g_set[0].wr_q;
  assign b_rd = g_set[1].rd_q;
  assign b_wr = g_set[1].wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      misc_q  <= '0;
      b_en_q  <= 1'b0;
      strap_q <= REG_W'(strap_pin);
    end else begin
      if (hw && addr == ADDR_W'(IDX_CTRL)) ctrl_q <= wbyte;
      if (hw && addr == ADDR_W'(IDX_MISC)) misc_q <= wbyte;
      if (!win_open && wr && !word && addr == ADDR_W'(IDX_CTRL) && wbyte == KEY_BEN)
        b_en_q <= 1'b1;
    end
  end

  always_comb begin
    if (addr == ADDR_W'(IDX_RDTIM))      rbyte = sel ? b_rd : a_rd;
    else if (addr == ADDR_W'(IDX_WRTIM)) rbyte = sel ? b_wr : a_wr;
    else if (addr == ADDR_W'(IDX_CTRL))  rbyte = ctrl_q;
    else if (addr == ADDR_W'(IDX_STRAP)) rbyte = strap_q;
    else if (addr == ADDR_W'(IDX_MISC))  rbyte = misc_q;
    else                                 rbyte = '1;
  end
endmodule

// File: rtl/hcw_outstage.sv
module hcw_outstage
  import hcw_pkg::*;
#(
  parameter int         REG_W   = 8,
  parameter logic [7:0] TIM_RST = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] a_rd,
  input  logic [REG_W-1:0] a_wr,
  input  logic [REG_W-1:0] b_rd,
  input  logic [REG_W-1:0] b_wr,
  input  logic [REG_W-1:0] ctrl_q,
  input  logic [REG_W-1:0] misc_q,
  output logic [REG_W-1:0] drv0_rd_tim,
  output logic [REG_W-1:0] drv0_wr_tim,
  output logic [REG_W-1:0] drv1_rd_tim,
  output logic [REG_W-1:0] drv1_wr_tim,
  output logic [REG_W-1:0] shared_cfg
);
  logic split;
  assign split = (ctrl_q == REG_W'(KEY_SPLIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      drv0_rd_tim <= REG_W'(TIM_RST);
      drv0_wr_tim <= REG_W'(TIM_RST);
      drv1_rd_tim <= REG_W'(TIM_RST);
      drv1_wr_tim <= REG_W'(TIM_RST);
      shared_cfg  <= '0;
    end else begin
      drv0_rd_tim <= a_rd;
      drv0_wr_tim <= a_wr;
      drv1_rd_tim <= split ? b_rd : a_rd;
      drv1_wr_tim <= split ? b_wr : a_wr;
      shared_cfg  <= misc_q;
    end
  end
endmodule

// File: rtl/hidden_cfg_window.sv
module hidden_cfg_window
  import hcw_pkg::*;
#(
  parameter int         ADDR_W  = 3,
  parameter int         DATA_W  = 16,
  parameter int         REG_W   = 8,
  parameter logic [7:0] TIM_RST = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_word,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] tf_addr,
  output logic              tf_rd,
  output logic              tf_wr,
  output logic              tf_word,
  output logic [DATA_W-1:0] tf_wdata,
  input  logic [DATA_W-1:0] tf_rdata,
  input  logic              strap_pin,
  output logic [REG_W-1:0]  drv0_rd_tim,
  output logic [REG_W-1:0]  drv0_wr_tim,
  output logic [REG_W-1:0]  drv1_rd_tim,
  output logic [REG_W-1:0]  drv1_wr_tim,
  output logic [REG_W-1:0]  shared_cfg
);
  localparam int PAD_W = DATA_W - REG_W;

  logic             win_open;
  seq_t             seq_q;
  logic [REG_W-1:0] wbyte, rbyte;
  logic [REG_W-1:0] a_rd, a_wr, b_rd, b_wr, ctrl_q, misc_q, strap_q;
  logic             b_en_q;

  assign wbyte = host_wdata[REG_W-1:0];

  hcw_unlock #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_unlock (
    .clk(clk), .rst(rst), .addr(host_addr), .rd(host_rd), .wr(host_wr),
    .word(host_word), .wbyte(wbyte), .win_open(win_open), .seq_q(seq_q)
  );

  hcw_bank #(.ADDR_W(ADDR_W), .REG_W(REG_W), .TIM_RST(TIM_RST)) u_bank (
    .clk(clk), .rst(rst), .strap_pin(strap_pin), .win_open(win_open),
    .addr(host_addr), .wr(host_wr), .word(host_word), .wbyte(wbyte),
    .rbyte(rbyte), .a_rd(a_rd), .a_wr(a_wr), .b_rd(b_rd), .b_wr(b_wr),
    .ctrl_q(ctrl_q), .misc_q(misc_q), .strap_q(strap_q), .b_en_q(b_en_q)
  );

  hcw_outstage #(.REG_W(REG_W), .TIM_RST(TIM_RST)) u_out (
    .clk(clk), .rst(rst), .a_rd(a_rd), .a_wr(a_wr), .b_rd(b_rd), .b_wr(b_wr),
    .ctrl_q(ctrl_q), .misc_q(misc_q),
    .drv0_rd_tim(drv0_rd_tim), .drv0_wr_tim(drv0_wr_tim),
    .drv1_rd_tim(drv1_rd_tim), .drv1_wr_tim(drv1_wr_tim),
    .shared_cfg(shared_cfg)
  );

  assign tf_addr    = host_addr;
  assign tf_word    = host_word;
  assign tf_wdata   = host_wdata;
  assign tf_rd      = host_rd && !win_open;
  assign tf_wr      = host_wr && !win_open;
  assign host_rdata = win_open ? {{PAD_W{1'b0}}, rbyte} : tf_rdata;
endmodule

// File: rtl/hcw_chk.sv
module hcw_chk
  import hcw_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_rd,
  input logic              host_wr,
  input logic              host_word,
  input logic [DATA_W-1:0] host_wdata,
  input logic              win_open,
  input seq_t              seq_q,
  input logic [REG_W-1:0]  ctrl_q,
  input logic [REG_W-1:0]  misc_q,
  input logic [REG_W-1:0]  strap_q,
  input logic              b_en_q,
  input logic [REG_W-1:0]  b_rd,
  input logic [REG_W-1:0]  b_wr,
  input logic [REG_W-1:0]  drv0_rd_tim,
  input logic [REG_W-1:0]  drv0_wr_tim,
  input logic [REG_W-1:0]  drv1_rd_tim,
  input logic [REG_W-1:0]  drv1_wr_tim,
  input logic [REG_W-1:0]  shared_cfg
);
  logic byte_wr;
  assign byte_wr = host_wr && !host_word;

  AST_OPEN_ON_KEY: assert property (@(posedge clk) disable iff (rst)
    (!win_open && seq_q == SEQ_TWO && byte_wr && host_addr == ADDR_W'(OFS_KEY)
     && host_wdata[REG_W-1:0] == KEY_OPEN) |=> win_open); // R2

  AST_NO_EARLY_OPEN: assert property (@(posedge clk) disable iff (rst)
    (!win_open && seq_q == SEQ_IDLE) |=> !win_open); // R3

  AST_CLOSE_ON_KEY: assert property (@(posedge clk) disable iff (rst)
    (win_open && byte_wr && host_addr == ADDR_W'(OFS_KEY)
     && host_wdata[REG_W-1:0] == KEY_CLOSE) |=> !win_open); // R5

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (byte_wr && host_addr == ADDR_W'(IDX_STRAP)) |=> $stable(strap_q)); // R6

  AST_B_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (!b_en_q && win_open && host_wr && misc_q[0]) |=> ($stable(b_rd) && $stable(b_wr))); // R8

  AST_DRV_SHARED: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q != REG_W'(KEY_SPLIT)) |=>
      (drv1_rd_tim == drv0_rd_tim && drv1_wr_tim == drv0_wr_tim)); // R9

  AST_MISC_OUT: assert property (@(posedge clk) disable iff (rst)
    (win_open && byte_wr && host_addr == ADDR_W'(IDX_MISC)) |=> ##1
      (shared_cfg == $past(host_wdata[REG_W-1:0], 2))); // R10
endmodule

bind hidden_cfg_window hcw_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
  .host_word(host_word), .host_wdata(host_wdata), .win_open(win_open), .seq_q(seq_q),
  .ctrl_q(ctrl_q), .misc_q(misc_q), .strap_q(strap_q), .b_en_q(b_en_q),
  .b_rd(b_rd), .b_wr(b_wr), .drv0_rd_tim(drv0_rd_tim), .drv0_wr_tim(drv0_wr_tim),
  .drv1_rd_tim(drv1_rd_tim), .drv1_wr_tim(drv1_wr_tim), .shared_cfg(shared_cfg)
);

// File: tb/hidden_cfg_window_bench.sv
module hidden_cfg_window_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0, host_word = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata, tf_wdata, tf_rdata;
  logic [2:0]  tf_addr;
  logic        tf_rd, tf_wr, tf_word;
  logic        strap_pin = 1'b1;
  logic [7:0]  drv0_rd_tim, drv0_wr_tim, drv1_rd_tim, drv1_wr_tim, shared_cfg;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  // task-file model: high byte 0xA5, low bits echo the offset
  assign tf_rdata = 16'hA500 | {13'b0, tf_addr};

  hidden_cfg_window u_hidden_cfg_window (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_word(host_word), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tf_addr(tf_addr), .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_word(tf_word),
    .tf_wdata(tf_wdata), .tf_rdata(tf_rdata), .strap_pin(strap_pin),
    .drv0_rd_tim(drv0_rd_tim), .drv0_wr_tim(drv0_wr_tim),
    .drv1_rd_tim(drv1_rd_tim), .drv1_wr_tim(drv1_wr_tim), .shared_cfg(shared_cfg)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic w, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_word = w; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic w, output logic [15:0] q);
    @(negedge clk);
    host_addr = a; host_word = w; host_rd = 1'b1;
    #1 q = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic unlock();
    logic [15:0] d;
    bus_rd(3'd1, 1'b1, d);
    bus_rd(3'd1, 1'b1, d);
    bus_wr(3'd2, 1'b0, 16'h0003);
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [7:0]  va;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    strap_pin = 1'b0;
    settle();

    // R11 reset state at the outputs
    check("R11 drv0_rd", {8'h0, drv0_rd_tim}, 16'h00FF);
    check("R11 drv1_wr", {8'h0, drv1_wr_tim}, 16'h00FF);
    check("R11 shared",  {8'h0, shared_cfg},  16'h0000);

    // R1 pass-through sweep over all offsets, reads and writes
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      host_addr = 3'(a); host_word = 1'b1; host_rd = 1'b1;
      #1;
      check("R1 rdata", host_rdata, 16'hA500 | 16'(a));
      check("R1 tf_rd/addr", {12'h0, tf_rd, tf_addr}, {12'h0, 1'b1, 3'(a)});
      @(negedge clk); host_rd = 1'b0;
      @(negedge clk);
      host_addr = 3'(a); host_word = 1'b0; host_wdata = 16'h1234 + 16'(a); host_wr = 1'b1;
      #1;
      check("R1 tf_wr/wdata", tf_wdata ^ {15'h0, !tf_wr}, 16'h1234 + 16'(a));
      @(negedge clk); host_wr = 1'b0;
    end

    // R3 broken patterns leave the window closed (index 5 reads task file)
    bus_rd(3'd1, 1'b1, d); bus_rd(3'd0, 1'b0, d); bus_rd(3'd1, 1'b1, d);
    bus_wr(3'd2, 1'b0, 16'h0003);
    bus_rd(3'd5, 1'b0, d); check("R3 stray read", d, 16'hA505);
    bus_rd(3'd1, 1'b1, d); bus_rd(3'd1, 1'b1, d);
    bus_wr(3'd2, 1'b1, 16'h0003);
    bus_rd(3'd5, 1'b0, d); check("R3 word key", d, 16'hA505);
    bus_rd(3'd1, 1'b1, d); bus_rd(3'd1, 1'b0, d); bus_rd(3'd1, 1'b1, d);
    bus_wr(3'd2, 1'b0, 16'h0003);
    bus_rd(3'd5, 1'b0, d); check("R3 byte arm read", d, 16'hA505);
    bus_rd(3'd1, 1'b1, d); bus_rd(3'd1, 1'b1, d);
    bus_wr(3'd2, 1'b0, 16'h0004);
    bus_rd(3'd5, 1'b0, d); check("R3 wrong key", d, 16'hA505);

    // R2 three arming reads still open; R6 strap latched at reset
    bus_rd(3'd1, 1'b1, d); bus_rd(3'd1, 1'b1, d); bus_rd(3'd1, 1'b1, d);
    bus_wr(3'd2, 1'b0, 16'h0003);
    bus_rd(3'd5, 1'b0, d); check("R2 R6 strap after open", d, 16'h0001);

    // R4 task file quiet while open
    @(negedge clk);
    host_addr = 3'd0; host_word = 1'b0; host_rd = 1'b1;
    #1 check("R4 tf_rd low", {15'h0, tf_rd}, 16'h0000);
    @(negedge clk); host_rd = 1'b0; host_wr = 1'b1; host_addr = 3'd7; host_wdata = 16'h0055;
    #1 check("R4 tf_wr low", {15'h0, tf_wr}, 16'h0000);
    @(negedge clk); host_wr = 1'b0;

    // R11 hidden index sweep after reset
    for (int i = 0; i < 8; i++) begin
      logic [15:0] e;
      case (i)
        3: e = 16'h0000;
        5: e = 16'h0001;
        6: e = 16'h0000;
        default: e = 16'h00FF;
      endcase
      bus_rd(3'(i), 1'b0, d);
      check("R11 R4 hidden index", d, e);
    end

    // R6 write to strap ignored
    bus_wr(3'd5, 1'b0, 16'h0000);
    bus_rd(3'd5, 1'b0, d); check("R6 strap write ignored", d, 16'h0001);

    // R8 set B locked before enable
    bus_wr(3'd6, 1'b0, 16'h0001);
    bus_wr(3'd0, 1'b0, 16'h0012);
    bus_wr(3'd1, 1'b0, 16'h0034);
    bus_rd(3'd0, 1'b0, d); check("R8 B rd locked", d, 16'h00FF);
    bus_rd(3'd1, 1'b0, d); check("R8 B wr locked", d, 16'h00FF);

    // R7 R9 set A sweep, both drives follow A
    bus_wr(3'd6, 1'b0, 16'h0000);
    for (int k = 0; k < 4; k++) begin
      va = 8'h5B - 8'(k * 16'h13);
      bus_wr(3'd0, 1'b0, {8'h0, va});
      bus_wr(3'd1, 1'b0, {8'h0, ~va});
      bus_rd(3'd0, 1'b0, d); check("R7 A rd", d, {8'h0, va});
      bus_rd(3'd1, 1'b0, d); check("R7 A wr", d, {8'h0, ~va});
      settle();
      check("R9 drv0 rd A", {8'h0, drv0_rd_tim}, {8'h0, va});
      check("R9 drv1 rd A", {8'h0, drv1_rd_tim}, {8'h0, va});
      check("R9 drv1 wr A", {8'h0, drv1_wr_tim}, {8'h0, ~va});
    end
    // last va = 0x5B - 3*0x13 = 0x22

    // R5 close
    bus_wr(3'd2, 1'b0, 16'h0083);
    bus_rd(3'd5, 1'b0, d); check("R5 closed", d, 16'hA505);

    // R8 enable B while closed, then reopen
    bus_wr(3'd3, 1'b0, 16'h00C0);
    unlock();
    bus_wr(3'd6, 1'b0, 16'h0001);
    bus_wr(3'd0, 1'b0, 16'h0048);
    bus_wr(3'd1, 1'b0, 16'h0034);
    bus_rd(3'd0, 1'b0, d); check("R8 R7 B rd", d, 16'h0048);
    bus_rd(3'd1, 1'b0, d); check("R8 R7 B wr", d, 16'h0034);
    bus_wr(3'd6, 1'b0, 16'h0000);
    bus_rd(3'd0, 1'b0, d); check("R7 A kept", d, 16'h0022);
    settle();
    check("R9 drv1 still A", {8'h0, drv1_rd_tim}, 16'h0022);

    // R9 split mode
    bus_wr(3'd3, 1'b0, 16'h0085);
    settle();
    check("R9 drv1 rd B", {8'h0, drv1_rd_tim}, 16'h0048);
    check("R9 drv1 wr B", {8'h0, drv1_wr_tim}, 16'h0034);
    check("R9 drv0 rd A", {8'h0, drv0_rd_tim}, 16'h0022);
    bus_rd(3'd3, 1'b0, d); check("R9 ctrl readback", d, 16'h0085);
    bus_wr(3'd3, 1'b0, 16'h0084);
    settle();
    check("R9 drv1 back to A", {8'h0, drv1_rd_tim}, 16'h0022);

    // R10 shared miscellaneous output sweep
    for (int m = 0; m < 4; m++) begin
      va = 8'h10 << m;
      bus_wr(3'd6, 1'b0, {8'h0, va});
      settle();
      check("R10 shared_cfg", {8'h0, shared_cfg}, {8'h0, va});
    end

    bus_wr(3'd2, 1'b0, 16'h0083);
    bus_rd(3'd0, 1'b1, d); check("R5 R1 pass-through again", d, 16'hA500);

    summary();
    $finish;
  end
endmodule